// File: doc/BRIEF.md
# NOR Flash Command Front End with Query Mode

This block models, in the synchronous domain, the command-decoding front end of a parallel NOR flash part. It watches the active-low chip-enable, write-enable and output-enable strobes, decides which bus cycles are real writes, and captures the address and data of each accepted write when the write cycle ends. A strobe pulse must survive a programmable number of clocks before it can count as a write. Writes are refused while the supply-good flag is low. Writes are also refused when the write condition is already present as reset is released.

Accepted writes drive a small mode machine with three states: array-read, autoselect and query. In query mode the read data port presents the identification table at word addresses 10h to 1Ah. The machine remembers whether query mode was entered from array-read or from autoselect, and a reset command returns to that mode. Array contents, program/erase algorithms and the remaining query geometry tables are not modelled. Read data outside query mode is zero.

Top module: `nor_cmd_front`

## Requirements
- R1: After RESET# deasserts, mode_o is 0 (array-read). rdata_o is 0000h whenever mode_o is not 2 (query).
- R2: A bus cycle counts as a write only while ce_ni=0, we_ni=0 and oe_ni=1. oe_ni=0 or ce_ni=1 during the cycle makes it ignored.
- R3: A write condition lasting fewer than FILT_CYC clocks (default 3) is rejected. One lasting FILT_CYC clocks or more is accepted.
- R4: Address and data are captured at the end of the write, when WE# or CE# rises. Each write produces exactly one command.
- R5: In array-read, a write of data low byte 98h to address 055h sets mode_o to 2. Only data bits 7:0 are compared, and the address is compared in full.
- R6: In array-read, a write of 90h to address 555h sets mode_o to 1 (autoselect). In autoselect, F0h written to any address returns mode_o to 0.
- R7: In autoselect, 98h written to 055h sets mode_o to 2. A later F0h returns mode_o to 1.
- R8: In query mode entered from array-read, F0h written to any address returns mode_o to 0.
- R9: In query mode, rdata_o is 0051h, 0052h and 0059h at addresses 10h, 11h and 12h. It is 0002h at 13h, 0040h at 15h, and 0000h at 14h, 16h and 17h through 1Ah.
- R10: In query mode, any other address reads 0000h. A write that matches no command leaves mode_o unchanged.
- R11: While pwr_ok_i=0, mode_o is forced to 0 from the next clock. Writes during that time are ignored, and the remembered entry mode is cleared.
- R12: If ce_ni=0, we_ni=0 and oe_ni=1 already hold when RESET# is released, the rise of WE# that ends that cycle is not taken as a command.
- R13: rst_ni=0 forces mode_o to 0 at once, without waiting for a clock, and clears the remembered entry mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | RESET#, active-low asynchronous reset |
| pwr_ok_i | input | 1 | Supply above lockout threshold |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W (12) | Word address |
| data_i | input | 16 | Write data bus |
| rdata_o | output | 16 | Read data (query table or zero) |
| mode_o | output | 2 | 0 array-read, 1 autoselect, 2 query |

## Verification
A wrong entry-mode memory stays hidden until a reset command is issued in query mode. At that point mode_o settles one clock after the command pulse, in autoselect instead of array-read or the other way round. A filter count that is off by one shows only at the FILT_CYC boundary, so pulses of exactly FILT_CYC-1 and FILT_CYC clocks are both driven. A faulty power-up guard shows as a mode change a few clocks after WE# rises, once the synchronizer latency has passed. A table fault shows on rdata_o within the same cycle the address is applied.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY = 2'd0,
    MODE_AUTO  = 2'd1,
    MODE_QUERY = 2'd2
  } mode_e;

  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] CMD_AUTO  = 8'h90;
  localparam logic [7:0] CMD_RESET = 8'hF0;

  localparam logic [15:0] QRY_Q = 16'h0051;
  localparam logic [15:0] QRY_R = 16'h0052;
  localparam logic [15:0] QRY_Y = 16'h0059;
endpackage

// File: rtl/nfc_strobe_qual.sv
module nfc_strobe_qual #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int FILT_CYC    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cmd_vld_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYC);

  logic [SYNC_STAGES-1:0] ce_q, we_q, oe_q;
  logic [ADDR_W-1:0] addr_q [SYNC_STAGES];
  logic [DATA_W-1:0] data_q [SYNC_STAGES];

  // pipeline resets to the write-active pattern so idle must be observed first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= '0;
      we_q <= '0;
      oe_q <= '1;
    end else begin
      ce_q <= {ce_q[SYNC_STAGES-2:0], ce_ni};
      we_q <= {we_q[SYNC_STAGES-2:0], we_ni};
      oe_q <= {oe_q[SYNC_STAGES-2:0], oe_ni};
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_bus_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[s] <= '0;
        data_q[s] <= '0;
      end else if (s == 0) begin
        addr_q[s] <= addr_i;
        data_q[s] <= data_i;
      end else begin
        addr_q[s] <= addr_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  end

  logic wr_raw, wr_cond, wr_cond_q, seen_idle;
  logic [CNT_W-1:0] cnt;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  assign wr_raw  = ~ce_q[SYNC_STAGES-1] & ~we_q[SYNC_STAGES-1] & oe_q[SYNC_STAGES-1];
  assign wr_cond = wr_raw & pwr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_idle <= 1'b0;
      wr_cond_q <= 1'b0;
      cnt       <= '0;
      hold_addr <= '0;
      hold_data <= '0;
      cmd_vld_o <= 1'b0;
    end else begin
      wr_cond_q <= wr_cond;
      if (!pwr_ok_i)   seen_idle <= 1'b0;
      else if (!wr_raw) seen_idle <= 1'b1;
      if (!wr_cond || !seen_idle)  cnt <= '0;
      else if (cnt != CNT_MAX)     cnt <= cnt + 1'b1;
      if (wr_cond) begin
        hold_addr <= addr_q[SYNC_STAGES-1];
        hold_data <= data_q[SYNC_STAGES-1];
      end
      cmd_vld_o <= wr_cond_q & ~wr_raw & (cnt == CNT_MAX) & pwr_ok_i;
    end
  end

  assign cmd_addr_o = hold_addr;
  assign cmd_data_o = hold_data;
endmodule

// File: rtl/nfc_mode_fsm.sv
module nfc_mode_fsm
  import nfc_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter int              DATA_W     = 16,
  parameter logic [ADDR_W-1:0] QUERY_ADDR = 'h055,
  parameter logic [ADDR_W-1:0] AUTO_ADDR  = 'h555
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              cmd_vld_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output mode_e             mode_o
);
  mode_e mode_q, mode_d;
  logic  from_auto_q, from_auto_d;
  logic  is_query, is_auto, is_reset;

  assign is_query = cmd_vld_i && cmd_data_i[7:0] == CMD_QUERY && cmd_addr_i == QUERY_ADDR;
  assign is_auto  = cmd_vld_i && cmd_data_i[7:0] == CMD_AUTO  && cmd_addr_i == AUTO_ADDR;
  assign is_reset = cmd_vld_i && cmd_data_i[7:0] == CMD_RESET;

  always_comb begin
    mode_d      = mode_q;
    from_auto_d = from_auto_q;
    unique case (mode_q)
      MODE_ARRAY: begin
        if (is_query) begin
          mode_d      = MODE_QUERY;
          from_auto_d = 1'b0;
        end else if (is_auto) begin
          mode_d = MODE_AUTO;
        end
      end
      MODE_AUTO: begin
        if (is_query) begin
          mode_d      = MODE_QUERY;
          from_auto_d = 1'b1;
        end else if (is_reset) begin
          mode_d = MODE_ARRAY;
        end
      end
      MODE_QUERY: begin
        if (is_reset) begin
          mode_d      = from_auto_q ? MODE_AUTO : MODE_ARRAY;
          from_auto_d = 1'b0;
        end
      end
      default: mode_d = MODE_ARRAY;
    endcase
    if (!pwr_ok_i) begin
      mode_d      = MODE_ARRAY;
      from_auto_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_ARRAY;
      from_auto_q <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      from_auto_q <= from_auto_d;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/nfc_query_rom.sv
module nfc_query_rom
  import nfc_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [15:0] PRI_CMD_SET = 16'h0002,
  parameter logic [15:0] PRI_EXT_PTR = 16'h0040
) (
  input  mode_e             mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [15:0]       rdata_o
);
  logic [15:0] word;

  always_comb begin
    word = 16'h0000;
    if (addr_i[ADDR_W-1:8] == '0) begin
      unique case (addr_i[7:0])
        8'h10:   word = QRY_Q;
        8'h11:   word = QRY_R;
        8'h12:   word = QRY_Y;
        8'h13:   word = PRI_CMD_SET;
        8'h15:   word = PRI_EXT_PTR;
        default: word = 16'h0000;
      endcase
    end
  end

  assign rdata_o = (mode_i == MODE_QUERY) ? word : 16'h0000;
endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front
  import nfc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int FILT_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  output logic [15:0]       rdata_o,
  output logic [1:0]        mode_o
);
  localparam int DATA_W = 16;

  logic              cmd_vld;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  mode_e             mode;

  nfc_strobe_qual #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILT_CYC(FILT_CYC), .SYNC_STAGES(2)
  ) u_qual (
    .clk_i, .rst_ni, .pwr_ok_i, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .cmd_vld_o(cmd_vld), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  nfc_mode_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .pwr_ok_i,
    .cmd_vld_i(cmd_vld), .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data),
    .mode_o(mode)
  );

  nfc_query_rom #(.ADDR_W(ADDR_W)) u_rom (
    .mode_i(mode), .addr_i, .rdata_o
  );

  assign mode_o = mode;
endmodule

// File: rtl/nfc_front_chk.sv
module nfc_front_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pwr_ok_i,
  input logic        cmd_vld,
  input logic [1:0]  mode_o,
  input logic [15:0] rdata_o
);
  a_r1_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  a_r1_zero_outside_query: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd2 |-> rdata_o == 16'h0000);

  a_r4_single_cmd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld |=> !cmd_vld);

  a_r11_supply_low_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> mode_o == 2'd0);

  a_r10_change_needs_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != $past(mode_o) |-> ($past(cmd_vld) || !$past(pwr_ok_i)));

  a_r8_query_exit_by_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 2'd2 && mode_o == 2'd0) |-> ($past(cmd_vld) || !$past(pwr_ok_i)));
endmodule

bind nor_cmd_front nfc_front_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok_i),
  .cmd_vld(cmd_vld), .mode_o(mode_o), .rdata_o(rdata_o)
);

// File: tb/nor_cmd_front_tb.sv
module nor_cmd_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [15:0] data = '0;
  logic [15:0] rdata;
  logic [1:0]  mode;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  nor_cmd_front #(.ADDR_W(12), .FILT_CYC(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .ce_ni(ce_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .data_i(data), .rdata_o(rdata), .mode_o(mode)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [11:0] a, logic [15:0] d, int hold,
                        logic ce_v = 1'b0, logic oe_v = 1'b1);
    @(negedge clk);
    addr = a; data = d; ce_n = ce_v; oe_n = oe_v; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd(string req, logic [11:0] a, logic [15:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R1 mode after reset", 16'(mode), 16'd0);
    rd("R1 rdata zero in array-read", 12'h010, 16'h0000);
  endtask

  task automatic t_glitch();
    bus_wr(12'h055, 16'h0098, 1);
    chk("R3 one-clock pulse rejected", 16'(mode), 16'd0);
    bus_wr(12'h055, 16'h0098, 2);
    chk("R3 FILT_CYC-1 pulse rejected", 16'(mode), 16'd0);
    bus_wr(12'h055, 16'h0098, 3);
    chk("R3 FILT_CYC pulse accepted", 16'(mode), 16'd2);
    bus_wr(12'h000, 16'h00F0, 6);
    chk("R8 reset command to array", 16'(mode), 16'd0);
  endtask

  task automatic t_inhibit();
    bus_wr(12'h055, 16'h0098, 6, 1'b0, 1'b0);
    chk("R2 OE low inhibits", 16'(mode), 16'd0);
    bus_wr(12'h055, 16'h0098, 6, 1'b1, 1'b1);
    chk("R2 CE high inhibits", 16'(mode), 16'd0);
  endtask

  task automatic t_query_table();
    bus_wr(12'h055, 16'hAB98, 6);
    chk("R5 query entry from array, high byte ignored", 16'(mode), 16'd2);
    rd("R9 addr 10h", 12'h010, 16'h0051);
    rd("R9 addr 11h", 12'h011, 16'h0052);
    rd("R9 addr 12h", 12'h012, 16'h0059);
    rd("R9 addr 13h", 12'h013, 16'h0002);
    rd("R9 addr 14h", 12'h014, 16'h0000);
    rd("R9 addr 15h", 12'h015, 16'h0040);
    rd("R9 addr 16h", 12'h016, 16'h0000);
    for (int i = 12'h017; i <= 12'h01A; i++) rd("R9 alternate fields", 12'(i), 16'h0000);
    rd("R10 unknown addr 1Bh", 12'h01B, 16'h0000);
    rd("R10 unknown addr 110h", 12'h110, 16'h0000);
    bus_wr(12'h555, 16'h0090, 6);
    chk("R10 unrecognised command in query", 16'(mode), 16'd2);
    bus_wr(12'h3C3, 16'h00F0, 6);
    chk("R8 F0 any addr returns array", 16'(mode), 16'd0);
    rd("R1 rdata zero after exit", 12'h010, 16'h0000);
  endtask

  task automatic t_autoselect();
    bus_wr(12'h056, 16'h0098, 6);
    chk("R10 wrong addr leaves mode", 16'(mode), 16'd0);
    bus_wr(12'h555, 16'h0090, 6);
    chk("R6 autoselect entry", 16'(mode), 16'd1);
    rd("R1 rdata zero in autoselect", 12'h010, 16'h0000);
    bus_wr(12'h055, 16'h0098, 6);
    chk("R7 query from autoselect", 16'(mode), 16'd2);
    rd("R9 table in query from autoselect", 12'h011, 16'h0052);
    bus_wr(12'h000, 16'h00F0, 6);
    chk("R7 reset returns to autoselect", 16'(mode), 16'd1);
    bus_wr(12'h000, 16'h00F0, 6);
    chk("R6 reset autoselect to array", 16'(mode), 16'd0);
  endtask

  task automatic t_capture_edge();
    // data changes after strobe fall; value present at WE# rise is used
    @(negedge clk);
    addr = 12'h055; data = 16'h0000; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b0;
    repeat (2) @(negedge clk);
    data = 16'h0098;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 data captured at strobe rise", 16'(mode), 16'd2);
    bus_wr(12'h000, 16'h00F0, 6);
  endtask

  task automatic t_power();
    bus_wr(12'h555, 16'h0090, 6);
    bus_wr(12'h055, 16'h0098, 6);
    @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk("R11 supply low forces array", 16'(mode), 16'd0);
    bus_wr(12'h055, 16'h0098, 6);
    chk("R11 write ignored while low", 16'(mode), 16'd0);
    pwr_ok = 1'b1;
    repeat (3) @(negedge clk);
    bus_wr(12'h055, 16'h0098, 6);
    chk("R11 query after supply return", 16'(mode), 16'd2);
    bus_wr(12'h000, 16'h00F0, 6);
    chk("R11 entry memory cleared", 16'(mode), 16'd0);
  endtask

  task automatic t_powerup_strobe();
    @(negedge clk);
    rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    addr = 12'h055; data = 16'h0098;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R12 power-up strobe not a command", 16'(mode), 16'd0);
    bus_wr(12'h055, 16'h0098, 6);
    chk("R12 normal write afterwards", 16'(mode), 16'd2);
  endtask

  task automatic t_async_reset();
    bus_wr(12'h000, 16'h00F0, 6);
    bus_wr(12'h555, 16'h0090, 6);
    bus_wr(12'h055, 16'h0098, 6);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 chk("R13 asynchronous force to array", 16'(mode), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_wr(12'h055, 16'h0098, 6);
    bus_wr(12'h000, 16'h00F0, 6);
    chk("R13 entry memory cleared", 16'(mode), 16'd0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_glitch();
    t_inhibit();
    t_query_table();
    t_autoselect();
    t_capture_edge();
    t_power();
    t_powerup_strobe();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule